// File: doc/BRIEF.md
# Fetch-Time Branch Predictor with Target Cache and History Table

The block predicts, during instruction fetch, whether the branch at the current fetch PC is taken and where it goes. It has two structures. The first is a small fully associative target cache. Each entry holds a branch PC, its target, a branch kind and its own prediction state. The second is a larger direct-mapped table of two-bit saturating history counters. Fetch presents a PC and receives a hit flag, a taken prediction and a target address, combinationally and in the same cycle.

The execute stage reports each resolved branch once, on a single-cycle resolve strobe. The report carries the branch PC, whether it is conditional, the actual outcome and the target. A conditional resolve trains the history table. A resolve that misses the target cache allocates an entry at a round-robin victim pointer. A resolve that hits trains the existing entry. A new entry predicts not taken until a later resolve of the same branch hits it. After that, an unconditional entry predicts taken. A conditional entry follows its own counter, which is seeded from the history table when the entry is allocated.

Top module: `br_dir_pred`

## Requirements
- R1: After the asynchronous reset, every history counter is strong not taken and the target cache is empty. Fetch of any PC then gives hit 0, taken 0 and target 0.
- R2: History counters use the encoding 00 strong not taken, 01 weak not taken, 10 weak taken and 11 strong taken. The prediction is taken when bit 1 is set. Each conditional resolve moves the counter one step toward its outcome, and the counter saturates at 00 and 11.
- R3: The history table is indexed by PC bits [10:2], so PCs that differ only above bit 10 share a counter. Unconditional resolves leave the history table unchanged.
- R4: On a target-cache miss, hit is 0, the taken prediction is bit 1 of the indexed history counter, and the target is 0.
- R5: A resolve whose PC misses the target cache writes the PC and target into the entry at the round-robin pointer. A later fetch of that PC hits and returns the stored target.
- R6: A newly allocated entry predicts not taken until a later resolve of the same PC hits it.
- R7: An unconditional entry that has been hit by a resolve predicts taken on every fetch hit.
- R8: A conditional entry is seeded with the history counter value read before the allocating resolve trains the table. Each later resolve hit steps the entry's counter with the R2 rule, and the fetch prediction is bit 1 of that counter.
- R9: The round-robin pointer starts at entry 0 and advances by one after each allocation, wrapping from the last entry to 0. With 64 entries, the 65th distinct branch evicts the first one and leaves the others resident.
- R10: A fetch in the same cycle as a resolve of the same PC sees the state from before the update. The update is visible from the next cycle.
- R11: A resolve that hits replaces the entry's stored target with the resolved target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fetch_pc_i | input | XLEN | Fetch PC to predict |
| pred_hit_o | output | 1 | Fetch PC found in the target cache |
| pred_taken_o | output | 1 | Predicted taken |
| pred_tgt_o | output | XLEN | Predicted target; 0 on a miss |
| res_valid_i | input | 1 | Resolve strobe, one cycle per resolved branch |
| res_pc_i | input | XLEN | PC of the resolved branch |
| res_cond_i | input | 1 | Resolved branch is conditional |
| res_taken_i | input | 1 | Actual outcome |
| res_tgt_i | input | XLEN | Actual target |

## Verification
The bench drives counters through both saturation ends. It observes them through an aliasing PC that misses the cache, so a counter that wraps would flip the prediction at either end. It checks that a fresh entry predicts not taken even when its history is weak taken. It also checks that the seed is the value read before the allocating resolve trains the table; seeding from reset state would leave the entry predicting not taken after the first taken hit. It fills all 64 entries and checks that only the oldest is evicted, which catches an off-by-one or non-wrapping pointer. It also resolves and fetches the same PC in one cycle, so a design that forwards the update would report a hit too early.

// File: rtl/bp_pkg.sv
package bp_pkg;

  typedef enum logic [1:0] {
    HC_SNT = 2'b00,
    HC_WNT = 2'b01,
    HC_WT  = 2'b10,
    HC_ST  = 2'b11
  } hctr_e;

  function automatic hctr_e hctr_step(input hctr_e c, input logic taken);
    hctr_e n;
    n = c;
    if (taken && c != HC_ST)       n = hctr_e'(2'(c) + 2'd1);
    else if (!taken && c != HC_SNT) n = hctr_e'(2'(c) - 2'd1);
    return n;
  endfunction

  function automatic logic hctr_pred(input hctr_e c);
    return c[1];
  endfunction

endpackage

// File: rtl/bp_hist_table.sv
module bp_hist_table
  import bp_pkg::*;
#(
  parameter int ENTRIES = 512,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output hctr_e            rd_ctr_o,
  input  logic             upd_en_i,
  input  logic [IDX_W-1:0] upd_idx_i,
  input  logic             upd_taken_i,
  output hctr_e            upd_ctr_o
);

  hctr_e hist_q [ENTRIES];

  assign rd_ctr_o  = hist_q[rd_idx_i];
  assign upd_ctr_o = hist_q[upd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) hist_q[i] <= HC_SNT;
    end else if (upd_en_i) begin
      hist_q[upd_idx_i] <= hctr_step(upd_ctr_o, upd_taken_i);
    end
  end

  a_r2_sat_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && upd_taken_i && upd_ctr_o == HC_ST) |=> hist_q[$past(upd_idx_i)] == HC_ST);

  a_r2_sat_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_en_i && !upd_taken_i && upd_ctr_o == HC_SNT) |=> hist_q[$past(upd_idx_i)] == HC_SNT);

endmodule

// File: rtl/bp_rr_ptr.sv
module bp_rr_ptr #(
  parameter int ENTRIES = 64,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [PTR_W-1:0] ptr_o
);

  logic [PTR_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_q <= '0;
    else if (adv_i) ptr_q <= (ptr_q == PTR_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  a_r9_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && ptr_o == PTR_W'(ENTRIES - 1)) |=> ptr_o == '0);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ptr_o));

endmodule

// File: rtl/bp_target_cache.sv
module bp_target_cache
  import bp_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int XLEN    = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] fetch_pc_i,
  output logic            hit_o,
  output logic            taken_o,
  output logic [XLEN-1:0] tgt_o,
  input  logic            res_valid_i,
  input  logic [XLEN-1:0] res_pc_i,
  input  logic            res_cond_i,
  input  logic            res_taken_i,
  input  logic [XLEN-1:0] res_tgt_i,
  input  hctr_e           res_hist_i
);

  logic            valid_q [ENTRIES];
  logic            fresh_q [ENTRIES];
  logic            cond_q  [ENTRIES];
  hctr_e           ctr_q   [ENTRIES];
  logic [XLEN-1:0] pc_q    [ENTRIES];
  logic [XLEN-1:0] tgt_q   [ENTRIES];

  logic [ENTRIES-1:0] f_match, r_match;
  logic [IDX_W-1:0]   f_idx, r_idx, ptr;
  logic               f_hit, r_hit, alloc;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign f_match[g] = valid_q[g] && (pc_q[g] == fetch_pc_i);
    assign r_match[g] = valid_q[g] && (pc_q[g] == res_pc_i);
  end

  // match vectors are one-hot or zero, so OR-ing indices encodes them
  always_comb begin
    f_idx = '0;
    r_idx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (f_match[i]) f_idx = f_idx | IDX_W'(i);
      if (r_match[i]) r_idx = r_idx | IDX_W'(i);
    end
  end

  assign f_hit = |f_match;
  assign r_hit = |r_match;
  assign alloc = res_valid_i && !r_hit;

  bp_rr_ptr #(.ENTRIES(ENTRIES)) u_rr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (alloc),
    .ptr_o (ptr)
  );

  always_comb begin
    hit_o   = f_hit;
    taken_o = 1'b0;
    tgt_o   = '0;
    if (f_hit) begin
      tgt_o = tgt_q[f_idx];
      if (!fresh_q[f_idx]) taken_o = cond_q[f_idx] ? hctr_pred(ctr_q[f_idx]) : 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        valid_q[i] <= 1'b0;
        fresh_q[i] <= 1'b0;
        cond_q[i]  <= 1'b0;
        ctr_q[i]   <= HC_SNT;
        pc_q[i]    <= '0;
        tgt_q[i]   <= '0;
      end
    end else if (res_valid_i) begin
      if (r_hit) begin
        fresh_q[r_idx] <= 1'b0;
        cond_q[r_idx]  <= res_cond_i;
        tgt_q[r_idx]   <= res_tgt_i;
        if (res_cond_i) ctr_q[r_idx] <= hctr_step(ctr_q[r_idx], res_taken_i);
      end else begin
        valid_q[ptr] <= 1'b1;
        fresh_q[ptr] <= 1'b1;
        cond_q[ptr]  <= res_cond_i;
        ctr_q[ptr]   <= res_hist_i;
        pc_q[ptr]    <= res_pc_i;
        tgt_q[ptr]   <= res_tgt_i;
      end
    end
  end

  a_r5_unique: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(f_match));

  a_r5_alloc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> valid_q[$past(ptr)] && fresh_q[$past(ptr)] && pc_q[$past(ptr)] == $past(res_pc_i));

  a_r7_uncond_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_i && r_hit && !res_cond_i) |=>
      (fetch_pc_i != $past(res_pc_i)) || (hit_o && taken_o));

endmodule

// File: rtl/br_dir_pred.sv
module br_dir_pred
  import bp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int TC_ENTRIES = 64,
  parameter int HT_ENTRIES = 512,
  localparam int HT_IDX_W  = $clog2(HT_ENTRIES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [XLEN-1:0] fetch_pc_i,
  output logic            pred_hit_o,
  output logic            pred_taken_o,
  output logic [XLEN-1:0] pred_tgt_o,
  input  logic            res_valid_i,
  input  logic [XLEN-1:0] res_pc_i,
  input  logic            res_cond_i,
  input  logic            res_taken_i,
  input  logic [XLEN-1:0] res_tgt_i
);

  hctr_e fetch_ctr, res_ctr;
  logic  tc_hit, tc_taken;

  bp_hist_table #(.ENTRIES(HT_ENTRIES)) u_hist (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_pc_i[HT_IDX_W+1:2]),
    .rd_ctr_o   (fetch_ctr),
    .upd_en_i   (res_valid_i && res_cond_i),
    .upd_idx_i  (res_pc_i[HT_IDX_W+1:2]),
    .upd_taken_i(res_taken_i),
    .upd_ctr_o  (res_ctr)
  );

  bp_target_cache #(.ENTRIES(TC_ENTRIES), .XLEN(XLEN)) u_tc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fetch_pc_i (fetch_pc_i),
    .hit_o      (tc_hit),
    .taken_o    (tc_taken),
    .tgt_o      (pred_tgt_o),
    .res_valid_i(res_valid_i),
    .res_pc_i   (res_pc_i),
    .res_cond_i (res_cond_i),
    .res_taken_i(res_taken_i),
    .res_tgt_i  (res_tgt_i),
    .res_hist_i (res_ctr)
  );

  assign pred_hit_o   = tc_hit;
  assign pred_taken_o = tc_hit ? tc_taken : hctr_pred(fetch_ctr);

  a_r4_miss_no_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_hit_o |-> pred_tgt_o == '0);

endmodule

// File: tb/br_dir_pred_bench.sv
`timescale 1ns/1ps
module br_dir_pred_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, tk;
  logic [31:0] tg;
  logic        res_valid = 1'b0, res_cond = 1'b0, res_taken = 1'b0;
  logic [31:0] res_pc = '0, res_tgt = '0;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  br_dir_pred u_br_dir_pred (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .pred_hit_o(hit), .pred_taken_o(tk), .pred_tgt_o(tg),
    .res_valid_i(res_valid), .res_pc_i(res_pc), .res_cond_i(res_cond),
    .res_taken_i(res_taken), .res_tgt_i(res_tgt)
  );

  localparam logic [31:0] PA = 32'h0000_0100, TA = 32'h0000_1100;
  localparam logic [31:0] PB = 32'h0000_0900, TB = 32'h0000_1900;
  localparam logic [31:0] PU = 32'h0000_0200, TU = 32'h0000_1200, TU2 = 32'h0000_2200;
  localparam logic [31:0] PD = 32'h0000_0300, TD = 32'h0000_1300;
  localparam logic [31:0] PE = 32'h4000_0000, TE = 32'h4000_0040;
  localparam logic [31:0] PF = 32'h8000_0000;

  // {resolved taken, expected history prediction afterwards}
  localparam logic [1:0] HIST_VEC [9] = '{
    2'b10, 2'b11, 2'b11, 2'b11, 2'b01, 2'b00, 2'b00, 2'b00, 2'b10
  };

  task automatic compare(input string tag, input logic eh, input logic et, input logic [31:0] eg);
    n_chk++;
    if (hit !== eh || tk !== et || tg !== eg) begin
      n_fail++;
      $display("FAIL %s: actual hit=%0b taken=%0b tgt=%h expected hit=%0b taken=%0b tgt=%h",
               tag, hit, tk, tg, eh, et, eg);
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] pc, input logic eh,
                     input logic et, input logic [31:0] eg);
    @(negedge clk);
    fetch_pc = pc;
    #1;
    compare(tag, eh, et, eg);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic cond, input logic taken,
                         input logic [31:0] tgt);
    @(negedge clk);
    res_pc = pc; res_cond = cond; res_taken = taken; res_tgt = tgt;
    res_valid = 1'b1;
    @(negedge clk);
    res_valid = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset state", PA, 1'b0, 1'b0, 32'h0);

    // R2 R3: train PA, observe the shared counter through aliasing PB (miss)
    for (int i = 0; i < 9; i++) begin
      resolve(PA, 1'b1, HIST_VEC[i][1], TA);
      chk($sformatf("R2 R3 R4 history row %0d", i), PB, 1'b0, HIST_VEC[i][0], 32'h0);
    end
    chk("R8 entry counter weak not taken", PA, 1'b1, 1'b0, TA);
    resolve(PA, 1'b1, 1'b1, TA);
    chk("R8 entry counter steps to weak taken", PA, 1'b1, 1'b1, TA);
    chk("R4 miss uses history weak taken", PB, 1'b0, 1'b1, 32'h0);

    // R6 R8: PB seeded from weak taken, fresh entry still not taken
    resolve(PB, 1'b1, 1'b1, TB);
    chk("R6 fresh conditional entry", PB, 1'b1, 1'b0, TB);
    resolve(PB, 1'b1, 1'b1, TB);
    chk("R8 seed from pre-update history", PB, 1'b1, 1'b1, TB);

    // unconditional
    resolve(PU, 1'b0, 1'b1, TU);
    chk("R5 R6 fresh unconditional entry", PU, 1'b1, 1'b0, TU);
    resolve(PU, 1'b0, 1'b1, TU);
    chk("R7 executed unconditional taken", PU, 1'b1, 1'b1, TU);
    chk("R3 unconditional leaves history", PU + 32'h800, 1'b0, 1'b0, 32'h0);
    resolve(PU, 1'b0, 1'b1, TU2);
    chk("R11 target refreshed on hit", PU, 1'b1, 1'b1, TU2);

    // R10 same-cycle resolve and fetch
    @(negedge clk);
    res_pc = PD; res_cond = 1'b1; res_taken = 1'b1; res_tgt = TD;
    res_valid = 1'b1;
    fetch_pc = PD;
    #1;
    compare("R10 same cycle sees old state", 1'b0, 1'b0, 32'h0);
    @(negedge clk);
    res_valid = 1'b0;
    #1;
    compare("R10 update visible next cycle", 1'b1, 1'b0, TD);

    // R9 fill remaining 60 entries, then evict entry 0
    for (int i = 0; i < 60; i++) resolve(PF + 32'(i) * 32'd16, 1'b0, 1'b1, PF + 32'(i) * 32'd16 + 32'd4);
    chk("R9 full cache keeps first entry", PA, 1'b1, 1'b1, TA);
    resolve(PE, 1'b0, 1'b1, TE);
    chk("R9 oldest entry evicted", PA, 1'b0, 1'b1, 32'h0);
    chk("R9 new entry at wrapped pointer", PE, 1'b1, 1'b0, TE);
    chk("R9 second entry survives", PB, 1'b1, 1'b1, TB);
    chk("R9 filled entry survives", PF, 1'b1, 1'b0, PF + 32'd4);

    // R1 reset clears everything again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset clears cache and history", PB, 1'b0, 1'b0, 32'h0);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=running expected=finished");
      summary();
      $finish;
    end
  end

endmodule